// File: doc/BRIEF.md
# Four-Bit Eight-Function ALU Slice with Ripple Chaining

This block is a purely combinational arithmetic logic unit. Each slice takes two 4-bit operands, a carry input and a 3-bit function code. It produces a 4-bit result, a carry output and a two's-complement overflow flag.

The eight function codes give:

- three arithmetic operations: add, and subtraction in either direction;
- three bitwise operations: XOR, OR and AND;
- two constant codes that force the result to all zeros or all ones.

Subtraction is formed as the minuend plus the bitwise complement of the subtrahend plus the carry input. The caller must therefore drive the carry input high to get a true two's-complement difference. The slice never supplies that +1 itself.

The top level is a parameterised ripple chain of slices. The carry output of each slice feeds the carry input of the next slice up. The function code is shared by all slices. Only the most significant slice's carry and overflow leave the block. With one slice, the top level is a single bare 4-bit ALU.

Top module: `alu_ripple_chain`

## Requirements
- R1: Function code 000 (clear) drives result to all zeros, with carry_out and overflow low.
- R2: Function code 111 (preset) drives result to all ones, with carry_out and overflow low.
- R3: Function code 011 (add) gives {carry_out, result} = lhs + rhs + carry_in, taken as unsigned numbers over the full word.
- R4: Function code 010 (lhs minus rhs) gives {carry_out, result} = lhs + ~rhs + carry_in. With carry_in high, result equals lhs - rhs modulo 2^width.
- R5: Function code 001 (rhs minus lhs) gives {carry_out, result} = rhs + ~lhs + carry_in. With carry_in high, result equals rhs - lhs modulo 2^width.
- R6: Function codes 100, 101 and 110 drive result to lhs XOR rhs, lhs OR rhs and lhs AND rhs, with carry_out and overflow low.
- R7: For function codes 000, 100, 101, 110 and 111, carry_in has no effect on any output.
- R8: For the three arithmetic codes, overflow is high exactly when the carry into the top bit differs from the carry out of it. This equals signed two's-complement overflow of the operation.
- R9: A chain of SLICES slices behaves as one SLICES*4-bit ALU for every function code. Carry and overflow come from the most significant slice.
- R10: Every output follows its inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhs | input | SLICES*SLICE_W | Left operand word |
| rhs | input | SLICES*SLICE_W | Right operand word |
| carry_in | input | 1 | Carry into the least significant slice |
| func | input | 3 | Function code, shared by all slices |
| result | output | SLICES*SLICE_W | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Two's-complement overflow of the most significant slice |

## Verification
The bench builds two copies of the block.

- With SLICES=1, every combination of the two 4-bit operands, the carry input and the function code is swept (4096 vectors). This exercises every carry pattern inside a slice and every case where carry_in must be ignored.
- With SLICES=4, the block becomes a 16-bit word. Pseudo-random vectors and chosen corners (0x7FFF+1, 0xFFFF+1, 0x8000-1) show the carry rippling across all slice boundaries. They also show that overflow is taken from the top slice only.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int SLICE_WIDTH = 4;
  localparam int FUNC_WIDTH  = 3;

  typedef enum logic [FUNC_WIDTH-1:0] {
    ALU_CLEAR     = 3'b000,
    ALU_R_MINUS_L = 3'b001,
    ALU_L_MINUS_R = 3'b010,
    ALU_ADD       = 3'b011,
    ALU_XOR       = 3'b100,
    ALU_OR        = 3'b101,
    ALU_AND       = 3'b110,
    ALU_PRESET    = 3'b111
  } alu_func_e;

  // True for the three codes that route the adder to the result.
  function automatic logic alu_is_arith(input alu_func_e f);
    return (f == ALU_ADD) || (f == ALU_L_MINUS_R) || (f == ALU_R_MINUS_L);
  endfunction

  // Signed overflow from operand and sum sign bits: same-sign inputs, other-sign output.
  function automatic logic alu_sign_overflow(input logic x_msb, input logic y_msb,
                                             input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = x ^ y;
  assign s    = half ^ ci;
  assign co   = (x & y) | (half & ci);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_top_in,
  output logic         c_out
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    alu_full_add u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(chain[i]),
      .s (sum[i]),
      .co(chain[i+1])
    );
  end

  assign c_top_in = chain[W-1];
  assign c_out    = chain[W];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  alu_func_e    op,
  output logic [W-1:0] value
);
  always_comb begin
    unique case (op)
      ALU_XOR:    value = lhs ^ rhs;
      ALU_OR:     value = lhs | rhs;
      ALU_AND:    value = lhs & rhs;
      ALU_PRESET: value = '1;
      default:    value = '0;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W = SLICE_WIDTH
) (
  input  logic [W-1:0]          lhs,
  input  logic [W-1:0]          rhs,
  input  logic                  carry_in,
  input  logic [FUNC_WIDTH-1:0] func,
  output logic [W-1:0]          result,
  output logic                  carry_out,
  output logic                  overflow
);
  alu_func_e    op;
  logic         arith;
  logic [W-1:0] add_x, add_y, add_sum, logic_val;
  logic         c_top_in, c_msb_out;

  assign op    = alu_func_e'(func);
  assign arith = alu_is_arith(op);

  // Operand steering: the subtrahend is inverted, the caller supplies the +1.
  always_comb begin
    unique case (op)
      ALU_R_MINUS_L: begin add_x = rhs; add_y = ~lhs; end
      ALU_L_MINUS_R: begin add_x = lhs; add_y = ~rhs; end
      default:       begin add_x = lhs; add_y = rhs;  end
    endcase
  end

  alu_ripple_adder #(.W(W)) u_adder (
    .x       (add_x),
    .y       (add_y),
    .cin     (carry_in),
    .sum     (add_sum),
    .c_top_in(c_top_in),
    .c_out   (c_msb_out)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .lhs  (lhs),
    .rhs  (rhs),
    .op   (op),
    .value(logic_val)
  );

  assign result    = arith ? add_sum : logic_val;
  assign carry_out = arith & c_msb_out;
  assign overflow  = arith & (c_top_in ^ c_msb_out);

  always_comb begin
    if (!$isunknown({lhs, rhs, carry_in, func})) begin
      // R3
      add_result_chk: assert (op != ALU_ADD ||
        {carry_out, result} == ({1'b0, lhs} + {1'b0, rhs} + (W+1)'(carry_in)));
      // R4
      lsub_diff_chk: assert (op != ALU_L_MINUS_R || !carry_in || result == W'(lhs - rhs));
      // R5
      rsub_diff_chk: assert (op != ALU_R_MINUS_L || !carry_in || result == W'(rhs - lhs));
      // R1
      clear_value_chk: assert (op != ALU_CLEAR || result == '0);
      // R2
      preset_value_chk: assert (op != ALU_PRESET || result == '1);
      // R6
      logic_flags_chk: assert (arith || (!carry_out && !overflow));
      // R8
      signed_ovf_chk: assert (!arith ||
        overflow == alu_sign_overflow(add_x[W-1], add_y[W-1], add_sum[W-1]));
    end
  end
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
  import alu_slice_pkg::*;
#(
  parameter int SLICES  = 4,
  parameter int SLICE_W = SLICE_WIDTH,
  localparam int TOTAL_W = SLICES * SLICE_W
) (
  input  logic [TOTAL_W-1:0]    lhs,
  input  logic [TOTAL_W-1:0]    rhs,
  input  logic                  carry_in,
  input  logic [FUNC_WIDTH-1:0] func,
  output logic [TOTAL_W-1:0]    result,
  output logic                  carry_out,
  output logic                  overflow
);
  logic [SLICES:0]   link;
  logic [SLICES-1:0] ovf_slice;

  assign link[0] = carry_in;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .lhs      (lhs[s*SLICE_W +: SLICE_W]),
      .rhs      (rhs[s*SLICE_W +: SLICE_W]),
      .carry_in (link[s]),
      .func     (func),
      .result   (result[s*SLICE_W +: SLICE_W]),
      .carry_out(link[s+1]),
      .overflow (ovf_slice[s])
    );
  end

  assign carry_out = link[SLICES];
  assign overflow  = ovf_slice[SLICES-1];

  always_comb begin
    if (!$isunknown({lhs, rhs, carry_in, func})) begin
      // R9
      chain_sum_chk: assert (alu_func_e'(func) != ALU_ADD ||
        {carry_out, result} == ({1'b0, lhs} + {1'b0, rhs} + (TOTAL_W+1)'(carry_in)));
      // R7
      chain_quiet_chk: assert (alu_is_arith(alu_func_e'(func)) ||
        ($countones(ovf_slice) == 0 && $countones(link[SLICES:1]) == 0));
    end
  end
endmodule

// File: tb/alu_ripple_chain_tb.sv
module alu_ripple_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Single slice, exhaustively swept.
  logic [3:0]  l1, r1, f1;
  logic        c1, co1, ov1;
  logic [2:0]  fn1;
  // Four slices, 16 bits.
  logic [15:0] l4, r4, f4;
  logic        c4, co4, ov4;
  logic [2:0]  fn4;

  alu_ripple_chain #(.SLICES(1), .SLICE_W(4)) u_dut (
    .lhs(l1), .rhs(r1), .carry_in(c1), .func(fn1),
    .result(f1), .carry_out(co1), .overflow(ov1)
  );

  alu_ripple_chain #(.SLICES(4), .SLICE_W(4)) u_chain (
    .lhs(l4), .rhs(r4), .carry_in(c4), .func(fn4),
    .result(f4), .carry_out(co4), .overflow(ov4)
  );

  // Arithmetic reference, written from the requirements.
  function automatic void model(input int w, input int l, input int r, input int c,
                                input int fn, output int res, output int co, output int ov);
    int mask, half, x, y, sum, sx, sy, ss;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    res = 0; co = 0; ov = 0;
    case (fn)
      0: res = 0;
      4: res = l ^ r;
      5: res = l | r;
      6: res = l & r;
      7: res = mask;
      default: begin
        if (fn == 1)      begin x = r; y = mask - l; end
        else if (fn == 2) begin x = l; y = mask - r; end
        else              begin x = l; y = r;        end
        sum = x + y + c;
        res = sum & mask;
        co  = (sum >> w) & 1;
        sx  = (x >= half) ? x - (1 << w) : x;
        sy  = (y >= half) ? y - (1 << w) : y;
        ss  = sx + sy + c;
        ov  = (ss > half - 1 || ss < -half) ? 1 : 0;
      end
    endcase
  endfunction

  function automatic string req_of(input int fn, input int c);
    case (fn)
      0: return "R1";
      1: return "R5";
      2: return "R4";
      3: return "R3";
      7: return "R2";
      default: return (c != 0) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check(input string req, input int got_r, input int got_c, input int got_v,
                       input int exp_r, input int exp_c, input int exp_v);
    checks++;
    if (got_r != exp_r || got_c != exp_c || got_v != exp_v) begin
      errors++;
      $display("FAIL %s: got result=%0h carry=%0d ovf=%0d expected result=%0h carry=%0d ovf=%0d",
               req, got_r, got_c, got_v, exp_r, exp_c, exp_v);
    end
  endtask

  task automatic run16(input int l, input int r, input int c, input int fn);
    int er, ec, ev;
    @(negedge clk);
    l4 = 16'(l); r4 = 16'(r); c4 = c[0]; fn4 = 3'(fn);
    #1;
    model(16, l, r, c, fn, er, ec, ev);
    check({"R9 ", req_of(fn, c)}, int'(f4), int'(co4), int'(ov4), er, ec, ev);
  endtask

  // Watchdog: an expired run is a failed check and still reaches the summary.
  initial begin
    for (int n = 0; n < WATCHDOG && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int er, ec, ev;
    bit [31:0] rng;
    l1 = '0; r1 = '0; c1 = 1'b0; fn1 = '0;
    l4 = '0; r4 = '0; c4 = 1'b0; fn4 = '0;
    repeat (3) @(posedge clk);
    // R1: state during reset, clear code with zero operands
    @(negedge clk);
    check("R1 reset", int'(f1), int'(co1), int'(ov1), 0, 0, 0);
    rst = 1'b0;

    // Exhaustive sweep of one slice: R1..R8
    for (int fn = 0; fn < 8; fn++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 16; l++)
          for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            l1 = 4'(l); r1 = 4'(r); c1 = c[0]; fn1 = 3'(fn);
            #1;
            model(4, l, r, c, fn, er, ec, ev);
            check(req_of(fn, c), int'(f1), int'(co1), int'(ov1), er, ec, ev);
          end

    // R10: two input changes within one clock period, no edge between them
    @(negedge clk);
    fn1 = 3'd3; c1 = 1'b0; l1 = 4'd5; r1 = 4'd2;
    #1;
    check("R10 first", int'(f1), int'(co1), int'(ov1), 7, 0, 0);
    l1 = 4'd7; r1 = 4'd1;
    #1;
    check("R10 second", int'(f1), int'(co1), int'(ov1), 8, 0, 1);

    // R9 corners on the 16-bit chain
    run16(16'h7FFF, 16'h0001, 0, 3);  // signed overflow, no carry
    run16(16'hFFFF, 16'h0001, 0, 3);  // carry across every slice
    run16(16'h8000, 16'h0001, 1, 2);  // R4 difference with signed overflow
    run16(16'h0001, 16'h8000, 1, 1);  // R5 difference with signed overflow
    run16(16'h1234, 16'h1234, 1, 2);  // zero difference, carry out high
    run16(16'h0F0F, 16'h00FF, 1, 4);
    run16(16'hA5A5, 16'hFFFF, 1, 7);
    run16(16'hA5A5, 16'hFFFF, 1, 0);

    rng = 32'h1D2C3B4A;
    for (int k = 0; k < 600; k++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      run16(int'(rng[15:0]), int'(rng[31:16]), int'(rng[8]), int'(rng[20:18]));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule